// File: doc/BRIEF.md
# Ethernet Receive Admission Filter

This block decides, frame by frame, whether an incoming Ethernet frame is taken in by the receive path. It watches the frame header one byte per clock and keeps the first six bytes, which form the destination address. When the end-of-frame strobe arrives with the frame length, it issues a one-cycle decision strobe with an accept flag.

The decision combines several checks. The receive path must be ready: the link is up, the bus master is enabled and the receive enable bit is set. The frame must not be oversized. The destination must either equal one of the valid exact-match entries or hit a set bit in a 4096-bit hashed multicast bitmap. Two saturating counters record hash-table acceptances and oversize drops.

Software programs the control word, the exact-match entries and the bitmap through a write-only port. The addresses are:
- 0x00 is the control word.
- 0x40 + 2·i is the low word of entry i, and 0x41 + 2·i is its high word.
- 0x80 + w is bitmap word w.

Top module: `rx_admit_filter`

## Requirements
- R1: A frame is accepted only if `link_up`, `bus_master_en` and control bit 0 (receive enable) are all 1 at end of frame. If any of them is 0, the frame is rejected and neither counter changes.
- R2: An exact-match entry matches when every destination byte equals the stored byte. Bytes 0..3 sit in the low word with byte 0 in bits 7:0. Byte 4 sits in high-word bits 7:0 and byte 5 in bits 15:8. A match accepts the frame and leaves the multicast counter unchanged.
- R3: An entry whose high-word bit 31 (valid) is 0 never matches.
- R4: With no exact match, the value {byte5, byte4} is shifted right by 4, 3, 2 or 0 for offset mode 0, 1, 2 or 3, which is held in control bits 5:4. The low 12 bits of the result form the hash. Hash bits 11:5 select the bitmap word and hash bits 4:0 select the bit in it, and a set bit accepts the frame.
- R5: Each frame that is accepted through the bitmap, and only such a frame, adds one to `mc_hit_cnt`.
- R6: A frame is oversized when its length exceeds 16384, or exceeds 1522 while control bit 1 (long packets) is 0. An oversized frame is rejected even if its address matches. Lengths of exactly 1522 and 16384 are not oversized.
- R7: When control bit 2 (store bad packets) is 1, the oversize rule is not applied.
- R8: Each oversized frame that reaches a ready receive path adds one to `oversize_cnt`.
- R9: Both counters stop at their all-ones value instead of wrapping.
- R10: The offset mode is captured with the first byte of a frame. A control write made mid-frame does not change that frame's hash.
- R11: `dec_vld` pulses for exactly one cycle, in the cycle after `rx_eof`. `dec_accept` is 1 only together with `dec_vld`.
- R12: After reset, both counters read 0, `dec_vld` is 0, all entries are invalid and the bitmap is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is up |
| bus_master_en | input | 1 | Bus mastering allowed |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| rx_vld | input | 1 | Header byte valid |
| rx_sof | input | 1 | First byte of a frame (with `rx_vld`) |
| rx_byte | input | 8 | Header byte |
| rx_eof | input | 1 | End of frame, length valid |
| rx_len | input | LEN_W | Frame length in bytes |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| mc_hit_cnt | output | CNT_W | Saturating hash-accept counter |
| oversize_cnt | output | CNT_W | Saturating oversize-drop counter |

## Verification
The bench builds the filter with `CNT_W = 4` and `NUM_EXACT = 4`. With 4-bit counters, saturation at 15 is reached after a few dozen frames, so both counters can be driven past their limit and shown to stick. With four entries, the bench can program a valid entry, an invalid entry, and entries that differ in a single byte within a short run. `LEN_W` stays at 16, so lengths on both sides of 1522 and 16384 can be applied.

// File: rtl/rx_admit_filter.sv
module rx_admit_filter #(
  parameter int NUM_EXACT = 16,
  parameter int CNT_W     = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_STD   = 1522,
  parameter int MAX_LONG  = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             bus_master_en,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             rx_vld,
  input  logic             rx_sof,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eof,
  input  logic [LEN_W-1:0] rx_len,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic [CNT_W-1:0] mc_hit_cnt,
  output logic [CNT_W-1:0] oversize_cnt
);
  localparam int HASH_WORDS = 128;
  localparam int HASH_W     = 12;

  logic [31:0] ctrl_q;
  logic [31:0] ent_lo [NUM_EXACT];
  logic [31:0] ent_hi [NUM_EXACT];
  logic [31:0] bitmap [HASH_WORDS];
  logic [7:0]  dst [6];
  logic [2:0]  idx;
  logic [1:0]  mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NUM_EXACT; i++) begin
        ent_lo[i] <= '0;
        ent_hi[i] <= '0;
      end
      for (int w = 0; w < HASH_WORDS; w++) bitmap[w] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 8'h00) ctrl_q <= cfg_wdata;
      if (cfg_addr[7]) bitmap[cfg_addr[6:0]] <= cfg_wdata;
      for (int i = 0; i < NUM_EXACT; i++) begin
        if (cfg_addr[7:6] == 2'b01 && int'(cfg_addr[5:1]) == i) begin
          if (cfg_addr[0]) ent_hi[i] <= cfg_wdata;
          else             ent_lo[i] <= cfg_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      mode_q <= '0;
      for (int b = 0; b < 6; b++) dst[b] <= '0;
    end else if (rx_vld) begin
      if (rx_sof) begin
        dst[0] <= rx_byte;
        idx    <= 3'd1;
        mode_q <= ctrl_q[5:4];
      end else if (idx < 3'd6) begin
        dst[idx] <= rx_byte;
        idx      <= idx + 3'd1;
      end
    end
  end

  wire rx_en = ctrl_q[0];
  wire lpe   = ctrl_q[1];
  wire sbp   = ctrl_q[2];
  wire ready = link_up & bus_master_en & rx_en;

  wire too_big = !sbp && ((32'(rx_len) > 32'(MAX_LONG)) ||
                          (!lpe && 32'(rx_len) > 32'(MAX_STD)));

  logic [NUM_EXACT-1:0] ent_hit;
  for (genvar g = 0; g < NUM_EXACT; g++) begin : g_ent
    assign ent_hit[g] = ent_hi[g][31] &&
                        ent_lo[g] == {dst[3], dst[2], dst[1], dst[0]} &&
                        ent_hi[g][15:0] == {dst[5], dst[4]};
  end
  wire exact = |ent_hit;

  logic [15:0] hash_src;
  always_comb begin
    case (mode_q)
      2'd0:    hash_src = {dst[5], dst[4]} >> 4;
      2'd1:    hash_src = {dst[5], dst[4]} >> 3;
      2'd2:    hash_src = {dst[5], dst[4]} >> 2;
      default: hash_src = {dst[5], dst[4]};
    endcase
  end
  wire [HASH_W-1:0] hash = hash_src[HASH_W-1:0];
  wire hash_hit = bitmap[hash[11:5]][hash[4:0]];

  wire take_mc = ready && !too_big && !exact && hash_hit;
  wire take_ov = ready && too_big;
  wire accept  = ready && !too_big && (exact || hash_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld      <= 1'b0;
      dec_accept   <= 1'b0;
      mc_hit_cnt   <= '0;
      oversize_cnt <= '0;
    end else begin
      dec_vld    <= rx_eof;
      dec_accept <= rx_eof && accept;
      if (rx_eof && take_mc && mc_hit_cnt != '1)   mc_hit_cnt   <= mc_hit_cnt + 1'b1;
      if (rx_eof && take_ov && oversize_cnt != '1) oversize_cnt <= oversize_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_admit_filter_chk.sv
module rx_admit_filter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_up,
  input logic             bus_master_en,
  input logic [31:0]      ctrl_q,
  input logic             rx_eof,
  input logic             dec_vld,
  input logic             dec_accept,
  input logic [CNT_W-1:0] mc_hit_cnt,
  input logic [CNT_W-1:0] oversize_cnt
);
  // R11
  strobe_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(rx_eof));
  // R11
  accept_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_vld);
  // R1
  gated_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !$past(link_up && bus_master_en && ctrl_q[0])) |-> !dec_accept);
  // R5
  mc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_hit_cnt != $past(mc_hit_cnt)) |->
      (dec_accept && mc_hit_cnt == CNT_W'($past(mc_hit_cnt) + 1'b1)));
  // R8
  ov_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oversize_cnt != $past(oversize_cnt)) |->
      (dec_vld && !dec_accept && oversize_cnt == CNT_W'($past(oversize_cnt) + 1'b1)));
  // R9
  mc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mc_hit_cnt) == '1) |-> (mc_hit_cnt == '1));
  // R9
  ov_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oversize_cnt) == '1) |-> (oversize_cnt == '1));
endmodule

bind rx_admit_filter rx_admit_filter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_admit_filter_tb.sv
module rx_admit_filter_tb;
  localparam int CW = 4;
  localparam int LW = 16;

  logic clk = 0, rst_n = 0;
  logic link_up = 0, bus_master_en = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rx_vld = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_byte = '0;
  logic [LW-1:0] rx_len = '0;
  logic dec_vld, dec_accept;
  logic [CW-1:0] mc_hit_cnt, oversize_cnt;

  int n_run = 0, n_fail = 0;
  int exp_mc = 0, exp_ov = 0;

  rx_admit_filter #(.NUM_EXACT(4), .CNT_W(CW), .LEN_W(LW)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= (1 << CW) - 1) ? (1 << CW) - 1 : v + 1;
  endfunction

  function automatic int hash_of(input logic [47:0] da, input int mode);
    int sh;
    logic [15:0] v;
    sh = (mode == 0) ? 4 : (mode == 1) ? 3 : (mode == 2) ? 2 : 0;
    v = {da[47:40], da[39:32]} >> sh;
    return int'(v[11:0]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [47:0] da, input int len, input bit midwr,
                      input logic [31:0] midval, output bit acc);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      rx_vld = 1; rx_sof = (b == 0); rx_byte = da[8*b +: 8];
      cfg_we = midwr && (b == 3); cfg_addr = 8'h00; cfg_wdata = midval;
    end
    @(negedge clk);
    rx_vld = 0; rx_sof = 0; cfg_we = 0;
    rx_eof = 1; rx_len = LW'(len);
    @(negedge clk);
    rx_eof = 0;
    chk("R11 strobe", int'(dec_vld), 1);
    acc = dec_accept;
    @(negedge clk);
    chk("R11 single", int'(dec_vld), 0);
  endtask

  task automatic cnt_check(input string req);
    chk({req, " mc cnt"}, int'(mc_hit_cnt), exp_mc);
    chk({req, " ov cnt"}, int'(oversize_cnt), exp_ov);
  endtask

  localparam logic [47:0] DA_A = 48'h665544332211;
  localparam logic [47:0] DA_M = 48'h12340000005E;

  task automatic t_reset();
    bit a;
    cnt_check("R12");
    chk("R12 dec_vld", int'(dec_vld), 0);
    link_up = 1; bus_master_en = 1;
    wr(8'h00, 32'h1);
    send(DA_A, 64, 0, 0, a);
    chk("R12 tables clear", int'(a), 0);
  endtask

  task automatic t_exact();
    bit a;
    wr(8'h42, 32'h44332211);
    wr(8'h43, 32'h8000_6655);
    send(DA_A, 100, 0, 0, a);
    chk("R2 exact accept", int'(a), 1);
    cnt_check("R2");
    send(DA_A ^ 48'h010000000000, 100, 0, 0, a);
    chk("R2 byte5 differs", int'(a), 0);
    send(DA_A ^ 48'h000000000001, 100, 0, 0, a);
    chk("R2 byte0 differs", int'(a), 0);
  endtask

  task automatic t_invalid();
    bit a;
    wr(8'h44, 32'h00000005E);
    wr(8'h45, 32'h0000_1234);
    send(DA_M, 100, 0, 0, a);
    chk("R3 invalid entry", int'(a), 0);
  endtask

  task automatic t_hash();
    bit a;
    for (int m = 0; m < 4; m++) begin
      int h;
      h = hash_of(DA_M, m);
      wr(8'h00, 32'h1 | (m << 4));
      wr(8'h80 | 8'(h >> 5), 32'h1 << (h & 31));
      send(DA_M, 200, 0, 0, a);
      chk("R4 hash accept", int'(a), 1);
      exp_mc = sat(exp_mc);
      cnt_check("R5");
      wr(8'h80 | 8'(h >> 5), 32'h0);
      send(DA_M, 200, 0, 0, a);
      chk("R4 hash clear", int'(a), 0);
      cnt_check("R5 miss");
    end
    wr(8'h00, 32'h1);
  endtask

  task automatic t_gate();
    bit a;
    int h;
    h = hash_of(DA_M, 0);
    wr(8'h80 | 8'(h >> 5), 32'h1 << (h & 31));
    link_up = 0;
    send(DA_M, 200, 0, 0, a);
    chk("R1 link down", int'(a), 0);
    send(DA_M, 3000, 0, 0, a);
    cnt_check("R1 link down");
    link_up = 1; bus_master_en = 0;
    send(DA_M, 200, 0, 0, a);
    chk("R1 no master", int'(a), 0);
    bus_master_en = 1;
    wr(8'h00, 32'h0);
    send(DA_A, 200, 0, 0, a);
    chk("R1 rx disabled", int'(a), 0);
    cnt_check("R1");
    wr(8'h00, 32'h1);
    send(DA_A, 200, 0, 0, a);
    chk("R1 all ready", int'(a), 1);
  endtask

  task automatic t_over();
    bit a;
    send(DA_A, 1522, 0, 0, a);
    chk("R6 1522 ok", int'(a), 1);
    send(DA_A, 1523, 0, 0, a);
    chk("R6 1523 drop", int'(a), 0);
    exp_ov = sat(exp_ov);
    cnt_check("R8");
    wr(8'h00, 32'h3);
    send(DA_A, 1523, 0, 0, a);
    chk("R6 long ok", int'(a), 1);
    send(DA_A, 16384, 0, 0, a);
    chk("R6 16384 ok", int'(a), 1);
    send(DA_A, 16385, 0, 0, a);
    chk("R6 16385 drop", int'(a), 0);
    exp_ov = sat(exp_ov);
    cnt_check("R8");
    wr(8'h00, 32'h5);
    send(DA_A, 20000, 0, 0, a);
    chk("R7 bypass", int'(a), 1);
    cnt_check("R7");
    wr(8'h00, 32'h1);
  endtask

  task automatic t_mode_latch();
    bit a;
    int h0, h3;
    h0 = hash_of(DA_M, 0);
    h3 = hash_of(DA_M, 3);
    wr(8'h80 | 8'(h3 >> 5), 32'h0);
    send(DA_M, 100, 1, 32'h31, a);
    chk("R10 latched mode0", int'(a), 1);
    exp_mc = sat(exp_mc);
    cnt_check("R10");
    wr(8'h80 | 8'(h0 >> 5), 32'h0);
    wr(8'h80 | 8'(h3 >> 5), 32'h1 << (h3 & 31));
    send(DA_M, 100, 1, 32'h01, a);
    chk("R10 latched mode3", int'(a), 1);
    exp_mc = sat(exp_mc);
    wr(8'h00, 32'h31);
  endtask

  task automatic t_sat();
    bit a;
    for (int i = 0; i < 20; i++) begin
      send(DA_M, 100, 0, 0, a);
      exp_mc = sat(exp_mc);
      send(DA_M, 3000, 0, 0, a);
      exp_ov = sat(exp_ov);
    end
    cnt_check("R9");
    chk("R9 mc top", int'(mc_hit_cnt), (1 << CW) - 1);
    chk("R9 ov top", int'(oversize_cnt), (1 << CW) - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_invalid();
    t_hash();
    t_gate();
    t_over();
    t_mode_latch();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule